// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divider

This unit divides a 64-bit dividend by a 32-bit divisor over many clock cycles, for use beside a 32-bit processor datapath. The dividend is built by taking a 32-bit extension register as the upper half and the low word of the first operand as the lower half. The divisor is the low word of the second operand. Either unsigned or two's-complement signed arithmetic can be chosen for each request. A quotient that cannot be represented in 32 bits is clamped to the nearest representable value, and an overflow bit is set. A zero divisor produces a one-cycle trap pulse and leaves every result register as it was.

A request is a single-cycle `start` pulse presented while the unit is idle. The state machine has three states: `S_IDLE`, `S_RUN` and `S_DONE`. From `S_IDLE` the request is accepted, and a non-zero divisor moves the machine to `S_RUN`. A zero divisor keeps it in `S_IDLE` and fires the trap. `S_RUN` develops one quotient bit per clock by restoring shift-subtract, 64 times, and then moves to `S_DONE`. `S_DONE` saturates the quotient, commits it, pulses `done` and returns to `S_IDLE`. When a request asks for a flag update, a condition-code set is written from the committed result. Requests that do not ask for it leave the flags alone.

Top module: `sdv_top`

## Requirements
- R1: The dividend is {y_in[31:0], op_a[31:0]} and the divisor is op_b[31:0]. Bits of op_a and op_b above bit 31 have no effect on the quotient, the overflow bit or the zero-divisor decision.
- R2: A request whose op_b[31:0] is zero raises dz_trap for exactly the one cycle after acceptance. It never raises done, leaves busy low, and leaves quot, ovf and the condition codes unchanged.
- R3: In unsigned mode (sgn_mode=0), a true quotient above 0xFFFFFFFF gives quot=0xFFFFFFFF with ovf=1.
- R4: In signed mode (sgn_mode=1), dividend 0x8000000000000000 divided by 0xFFFFFFFF (-1) gives quot=0x7FFFFFFF with ovf=1.
- R5: In signed mode, a true quotient below -2^31 gives quot=0x80000000, and one above 2^31-1 gives quot=0x7FFFFFFF, both with ovf=1. A quotient of exactly -2^31 is exact with ovf=0.
- R6: A quotient that fits is the exact quotient truncated toward zero, with ovf=0, in both modes.
- R7: When set_cc=1, cc_we pulses together with done, with cc_n=quot[31], cc_z=(quot==0), cc_v=ovf and cc_c=0. When set_cc=0, cc_we stays low and cc_n, cc_z, cc_v and cc_c keep their values.
- R8: busy is high from the cycle after acceptance, and done is a one-cycle pulse 66 cycles after the accepting edge, during which busy is low.
- R9: A start presented while busy is high is ignored, and the running request completes with its own result.
- R10: After reset, busy, done, dz_trap, quot, ovf, cc_we and all condition-code outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| sgn_mode | input | 1 | 1 = signed divide, 0 = unsigned |
| set_cc | input | 1 | 1 = write condition codes at completion |
| y_in | input | 32 | Upper half of the dividend |
| op_a | input | 64 | First operand; low 32 bits form the lower dividend half |
| op_b | input | 64 | Second operand; low 32 bits form the divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | 32 | Committed, saturated quotient |
| ovf | output | 1 | Committed overflow bit |
| dz_trap | output | 1 | One-cycle divide-by-zero trap pulse |
| cc_we | output | 1 | Condition-code write strobe |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_v | output | 1 | Overflow flag |
| cc_c | output | 1 | Carry flag, always written 0 |

## Verification
The assertions check on every cycle the properties that hold at the interface. done and dz_trap never coincide with busy. A trap cycle leaves quot and ovf untouched. Flag outputs move only under cc_we, and cc_v then agrees with ovf. An overflowing quotient is always one of the saturation constants for its mode. A start arriving in `S_RUN` leaves the captured divisor alone. Only the directed scenarios can show that specific quotients are numerically correct against a 64-bit reference, that the latency is exactly 66 cycles, and that upper operand bits are really ignored. The same goes for the -2^31 boundary staying exact and an ignored mid-run start not disturbing the result.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } sdv_state_e;
endpackage

// File: rtl/sdv_prep.sv
// Builds the 64-bit dividend and converts both operands to magnitudes.
module sdv_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0]   hi_word,
    input  logic [W-1:0]   lo_word,
    input  logic [W-1:0]   dsr_word,
    input  logic           sgn,
    output logic [2*W-1:0] dvd_mag,
    output logic [W-1:0]   dsr_mag,
    output logic           q_neg,
    output logic           dsr_zero
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_raw;
    logic          dvd_neg;
    logic          dsr_neg;

    always_comb begin
        dvd_raw  = {hi_word, lo_word};
        dvd_neg  = sgn & dvd_raw[DW-1];
        dsr_neg  = sgn & dsr_word[W-1];
        dvd_mag  = dvd_neg ? (DW'(0) - dvd_raw) : dvd_raw;
        dsr_mag  = dsr_neg ? (W'(0) - dsr_word) : dsr_word;
        q_neg    = dvd_neg ^ dsr_neg;
        dsr_zero = (dsr_word == '0);
    end
endmodule

// File: rtl/sdv_step.sv
// One restoring shift-subtract iteration.
module sdv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0]   rem_in,
    input  logic [2*W-1:0] dvd_in,
    input  logic [W-1:0]   dsr,
    output logic [W-1:0]   rem_out,
    output logic [2*W-1:0] dvd_out
);
    localparam int DW = 2 * W;

    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {rem_in, dvd_in[DW-1]};
        fits    = (shifted >= {1'b0, dsr});
        trial   = shifted - {1'b0, dsr};
        rem_out = fits ? trial[W-1:0] : shifted[W-1:0];
        dvd_out = {dvd_in[DW-2:0], fits};
    end
endmodule

// File: rtl/sdv_clamp.sv
// Applies sign and saturation to the 64-bit quotient magnitude.
module sdv_clamp #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] q_mag,
    input  logic           q_neg,
    input  logic           sgn,
    output logic [W-1:0]   res,
    output logic           ovf
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] NEG_LIM = DW'(1) << (W - 1);
    localparam logic [W-1:0]  POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  NEG_MIN = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (!sgn) begin
            ovf = |q_mag[DW-1:W];
            res = ovf ? '1 : q_mag[W-1:0];
        end else if (!q_neg) begin
            ovf = |q_mag[DW-1:W-1];
            res = ovf ? POS_MAX : q_mag[W-1:0];
        end else begin
            ovf = (q_mag > NEG_LIM);
            res = ovf ? NEG_MIN : (W'(0) - q_mag[W-1:0]);
        end
    end
endmodule

// File: rtl/sdv_top.sv
module sdv_top
    import sdv_pkg::*;
#(
    parameter int W   = 32,
    parameter int OPW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           sgn_mode,
    input  logic           set_cc,
    input  logic [W-1:0]   y_in,
    input  logic [OPW-1:0] op_a,
    input  logic [OPW-1:0] op_b,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   quot,
    output logic           ovf,
    output logic           dz_trap,
    output logic           cc_we,
    output logic           cc_n,
    output logic           cc_z,
    output logic           cc_v,
    output logic           cc_c
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);
    localparam logic [W-1:0]  POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  NEG_MIN = {1'b1, {(W-1){1'b0}}};

    sdv_state_e state_q, state_d;

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q;
    logic [DW-1:0] dvd_q;
    logic [W-1:0]  dsr_q;
    logic          neg_q, sgn_q, ccreq_q;

    logic [DW-1:0] p_dvd;
    logic [W-1:0]  p_dsr;
    logic          p_neg, p_zero;
    logic [W-1:0]  s_rem;
    logic [DW-1:0] s_dvd;
    logic [W-1:0]  c_res;
    logic          c_ovf;

    logic [W-1:0]  quot_q;
    logic          ovf_q, done_q, trap_q, ccwe_q, ccn_q, ccz_q, ccv_q, ccc_q;

    sdv_prep #(.W(W)) u_prep (
        .hi_word (y_in),
        .lo_word (op_a[W-1:0]),
        .dsr_word(op_b[W-1:0]),
        .sgn     (sgn_mode),
        .dvd_mag (p_dvd),
        .dsr_mag (p_dsr),
        .q_neg   (p_neg),
        .dsr_zero(p_zero)
    );

    sdv_step #(.W(W)) u_step (
        .rem_in (rem_q),
        .dvd_in (dvd_q),
        .dsr    (dsr_q),
        .rem_out(s_rem),
        .dvd_out(s_dvd)
    );

    sdv_clamp #(.W(W)) u_clamp (
        .q_mag(dvd_q),
        .q_neg(neg_q),
        .sgn  (sgn_q),
        .res  (c_res),
        .ovf  (c_ovf)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start && !p_zero) state_d = S_RUN;
            S_RUN:  if (cnt_q == LAST)    state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rem_q   <= '0;
            dvd_q   <= '0;
            dsr_q   <= '0;
            neg_q   <= 1'b0;
            sgn_q   <= 1'b0;
            ccreq_q <= 1'b0;
            quot_q  <= '0;
            ovf_q   <= 1'b0;
            done_q  <= 1'b0;
            trap_q  <= 1'b0;
            ccwe_q  <= 1'b0;
            ccn_q   <= 1'b0;
            ccz_q   <= 1'b0;
            ccv_q   <= 1'b0;
            ccc_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            ccwe_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start && p_zero) begin
                        trap_q <= 1'b1;
                    end else if (start) begin
                        cnt_q   <= '0;
                        rem_q   <= '0;
                        dvd_q   <= p_dvd;
                        dsr_q   <= p_dsr;
                        neg_q   <= p_neg;
                        sgn_q   <= sgn_mode;
                        ccreq_q <= set_cc;
                    end
                end
                S_RUN: begin
                    rem_q <= s_rem;
                    dvd_q <= s_dvd;
                    cnt_q <= cnt_q + 1'b1;
                end
                S_DONE: begin
                    quot_q <= c_res;
                    ovf_q  <= c_ovf;
                    done_q <= 1'b1;
                    if (ccreq_q) begin
                        ccwe_q <= 1'b1;
                        ccn_q  <= c_res[W-1];
                        ccz_q  <= (c_res == '0);
                        ccv_q  <= c_ovf;
                        ccc_q  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state_q != S_IDLE);
    assign done    = done_q;
    assign quot    = quot_q;
    assign ovf     = ovf_q;
    assign dz_trap = trap_q;
    assign cc_we   = ccwe_q;
    assign cc_n    = ccn_q;
    assign cc_z    = ccz_q;
    assign cc_v    = ccv_q;
    assign cc_c    = ccc_q;

    p_trap_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (!busy && !done_q));
    p_trap_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> ($stable(quot_q) && $stable(ovf_q)));
    p_uns_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ovf_q && !sgn_q) |-> (quot_q == '1));
    p_sgn_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ovf_q && sgn_q) |-> (quot_q == POS_MAX || quot_q == NEG_MIN));
    p_cc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ccn_q, ccz_q, ccv_q, ccc_q}) |-> ccwe_q);
    p_cc_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ccwe_q |-> (ccv_q == ovf_q && done_q));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy);
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && start) |=> $stable(dsr_q));
endmodule

// File: tb/sim_sdv_top.sv
module sim_sdv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, sgn_mode = 1'b0, set_cc = 1'b0;
    logic [31:0] y_in = '0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        busy, done, ovf, dz_trap, cc_we, cc_n, cc_z, cc_v, cc_c;
    logic [31:0] quot;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdv_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
        .set_cc(set_cc), .y_in(y_in), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .quot(quot), .ovf(ovf), .dz_trap(dz_trap),
        .cc_we(cc_we), .cc_n(cc_n), .cc_z(cc_z), .cc_v(cc_v), .cc_c(cc_c)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] y, input logic [63:0] a, input logic [63:0] b,
                         input bit sgn, output logic [31:0] q, output bit ov);
        if (!sgn) begin
            longint unsigned x, d, r;
            x = {y, a[31:0]};
            d = {32'd0, b[31:0]};
            r = x / d;
            ov = (r > 64'hFFFF_FFFF);
            q  = ov ? 32'hFFFF_FFFF : r[31:0];
        end else begin
            longint x, d, r;
            int bi;
            x  = {y, a[31:0]};
            bi = b[31:0];
            d  = bi;
            if (d == -1 && x == 64'sh8000_0000_0000_0000) begin
                ov = 1'b1; q = 32'h7FFF_FFFF;
            end else begin
                r = x / d;
                if (r > 64'sd2147483647)       begin ov = 1'b1; q = 32'h7FFF_FFFF; end
                else if (r < -64'sd2147483648) begin ov = 1'b1; q = 32'h8000_0000; end
                else                           begin ov = 1'b0; q = r[31:0]; end
            end
        end
    endtask

    // Issues one request and waits for done or trap; lat counts negedges after drive.
    task automatic issue(input logic [31:0] y, input logic [63:0] a, input logic [63:0] b,
                         input bit sgn, input bit cc, output int lat);
        @(negedge clk);
        start = 1'b1; sgn_mode = sgn; set_cc = cc; y_in = y; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && !dz_trap && lat < 120) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Full division scenario with result and flag checks.
    task automatic t_div(input string req, input logic [31:0] y, input logic [63:0] a,
                         input logic [63:0] b, input bit sgn, input bit cc);
        logic [31:0] eq;
        bit eo;
        logic [3:0] cc_before;
        int lat;
        model(y, a, b, sgn, eq, eo);
        cc_before = {cc_n, cc_z, cc_v, cc_c};
        issue(y, a, b, sgn, cc, lat);
        chk(done && !busy, {req, " R8 done pulse idle"}, {done, busy}, 2'b10);
        chk(lat == 66, {req, " R8 latency"}, lat, 66);
        chk(quot == eq, {req, " quotient"}, quot, eq);
        chk(ovf == eo, {req, " overflow"}, ovf, eo);
        if (cc) begin
            chk(cc_we && cc_n == eq[31] && cc_z == (eq == 0) && cc_v == eo && !cc_c,
                {req, " R7 cc write"}, {cc_we, cc_n, cc_z, cc_v, cc_c},
                {1'b1, eq[31], eq == 0, eo, 1'b0});
        end else begin
            chk(!cc_we && {cc_n, cc_z, cc_v, cc_c} == cc_before, {req, " R7 cc hold"},
                {cc_we, cc_n, cc_z, cc_v, cc_c}, {1'b0, cc_before});
        end
        @(negedge clk);
        chk(!done, {req, " R8 done one cycle"}, done, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !dz_trap && quot == 0 && !ovf && !cc_we &&
            !cc_n && !cc_z && !cc_v && !cc_c, "R10 reset state",
            {busy, done, dz_trap, ovf, cc_we, cc_n, cc_z, cc_v, cc_c, quot},
            '0);
    endtask

    task automatic t_zero_div();
        logic [31:0] q0;
        logic [4:0] f0;
        int lat;
        bit saw_done;
        q0 = quot;
        f0 = {ovf, cc_n, cc_z, cc_v, cc_c};
        issue(32'h1, 64'h5, 64'hABCD_0000_0000_0000, 1'b0, 1'b1, lat);
        chk(dz_trap && lat == 1 && !busy, "R2 R1 trap on low-zero divisor",
            {dz_trap, busy, 8'(lat)}, {1'b1, 1'b0, 8'd1});
        @(negedge clk);
        chk(!dz_trap, "R2 trap one cycle", dz_trap, 0);
        saw_done = 1'b0;
        for (int i = 0; i < 70; i++) begin
            if (done || busy) saw_done = 1'b1;
            @(negedge clk);
        end
        chk(!saw_done, "R2 no done/busy after trap", saw_done, 0);
        chk(quot == q0 && {ovf, cc_n, cc_z, cc_v, cc_c} == f0, "R2 results unchanged",
            {ovf, cc_n, cc_z, cc_v, cc_c, quot}, {f0, q0});
    endtask

    task automatic t_busy_start();
        int lat;
        logic [31:0] eq;
        bit eo;
        model(32'h0, 64'd1000, 64'd10, 1'b0, eq, eo);
        @(negedge clk);
        start = 1'b1; sgn_mode = 1'b0; set_cc = 1'b0; y_in = 0; op_a = 64'd1000; op_b = 64'd10;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy, "R8 busy during run", busy, 1);
        start = 1'b1; sgn_mode = 1'b1; y_in = 32'h7; op_a = 64'd3; op_b = 64'd0;
        @(negedge clk);
        start = 1'b0;
        lat = 12;
        while (!done && !dz_trap && lat < 120) begin
            @(negedge clk);
            lat++;
        end
        chk(done && !dz_trap && lat == 66, "R9 ignored start, timing", {done, dz_trap, 8'(lat)},
            {1'b1, 1'b0, 8'd66});
        chk(quot == eq && ovf == eo, "R9 original result", {ovf, quot}, {eo, eq});
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div("R6 unsigned small", 32'h0, 64'd100, 64'd7, 1'b0, 1'b0);
        t_div("R1 upper bits ignored", 32'h3, 64'hDEAD_BEEF_0000_0000, 64'hFFFF_0000_0000_0010,
              1'b0, 1'b0);
        t_div("R3 unsigned saturate", 32'h1, 64'h0, 64'h1, 1'b0, 1'b1);
        t_div("R4 min div minus one", 32'h8000_0000, 64'h0, 64'hFFFF_FFFF, 1'b1, 1'b1);
        t_div("R5 negative saturate", 32'hFFFF_FF00, 64'h0, 64'h1, 1'b1, 1'b1);
        t_div("R5 positive saturate", 32'h1, 64'h0, 64'h2, 1'b1, 1'b0);
        t_div("R5 exact min boundary", 32'hFFFF_FFFF, 64'h8000_0000, 64'h1, 1'b1, 1'b1);
        t_div("R6 signed negative", 32'hFFFF_FFFF, 64'hFFFF_FF9C, 64'd7, 1'b1, 1'b1);
        t_div("R6 signed neg divisor", 32'h0, 64'd100, 64'hFFFF_FFF9, 1'b1, 1'b0);
        t_div("R7 zero flag", 32'h0, 64'd5, 64'd7, 1'b0, 1'b1);
        t_div("R7 cc untouched", 32'h0, 64'd77, 64'd3, 1'b0, 1'b0);
        t_zero_div();
        t_busy_start();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule